// File: doc/BRIEF.md
# Vendor Request to MDIO Management Bridge

This block sits behind a USB device controller's control endpoint. The controller hands it each 8-byte SETUP packet as one 64-bit word with a one-cycle valid strobe. Byte 0 of the packet sits in bits 7:0 and byte 7 in bits 63:56. The bridge acts on three vendor request codes: a probe, a management-register write and a management-register read. The write and read requests become single transactions on an MDIO master. That master is outside the block and is driven through a level request that is held until a done pulse comes back.

When the transaction has finished, the bridge builds the data-stage reply. It drives the reply bytes and a byte count, marks them with a one-cycle arm pulse, and then pulses a handshake acknowledge so the controller can close the status stage. A write reply echoes the request parameters together with the 16-bit management frame header that was issued. A read reply echoes the request parameters together with the register value that was returned. Packets that are not vendor requests, and request codes that are not recognised, are dropped without any effect.

Top module: `vreq_mdio_bridge`

## Requirements
- R1: After synchronous reset, mdio_req, reply_arm and hs_ack are 0, reply_len is 0 and reply_data is all zeros.
- R2: A vendor packet (byte 0 bits 6:5 equal to 2'b10) with request code 0x20 in byte 1 starts no MDIO transaction. It produces reply_len 1 with reply byte 0 equal to 0x15, with reply_arm high on the second clock edge after the accepted strobe.
- R3: Request code 0x21 raises mdio_req with mdio_write=1 on the edge that accepts the packet. The PHY address is byte 2 bits 4:0, the register is byte 3 bits 4:0, and mdio_wdata is {byte 5, byte 4}.
- R4: Request code 0x22 raises mdio_req with mdio_write=0, taking the PHY and register addresses from bytes 2 and 3 in the same way as R3.
- R5: Write and read replies have reply_len 8, and reply bytes 0 to 5 equal setup bytes 2 to 7 in that order.
- R6: In a read reply, byte 6 is mdio_rdata[15:8] and byte 7 is mdio_rdata[7:0], with mdio_rdata sampled on the cycle mdio_done is high.
- R7: In a write reply, byte 6 is the low byte and byte 7 the high byte of the frame header {2'b01, op, phy[4:0], reg[4:0], 2'b10}, where op is 2'b01 for write.
- R8: mdio_req falls on the edge that samples mdio_done high. reply_arm is a one-cycle pulse on the following edge, so no reply is armed before the transaction reports done.
- R9: hs_ack is a one-cycle pulse on the edge after reply_arm.
- R10: An unrecognised request code causes no mdio_req, no reply_arm and no hs_ack.
- R11: A packet whose byte 0 bits 6:5 are not 2'b10 is ignored, even when it carries a known code.
- R12: While a request is in progress (from acceptance to hs_ack), further setup strobes are ignored. mdio_req stays high and the MDIO fields stay stable until mdio_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_valid | input | 1 | One-cycle strobe: setup_data holds a SETUP packet |
| setup_data | input | 64 | SETUP packet, byte n at bits 8n+7:8n |
| mdio_req | output | 1 | Transaction request, held until mdio_done |
| mdio_write | output | 1 | 1 = write, 0 = read |
| mdio_phy | output | PHY_W | PHY address |
| mdio_reg | output | REG_W | Register address |
| mdio_wdata | output | DATA_W | Write data |
| mdio_done | input | 1 | Transaction complete pulse |
| mdio_rdata | input | DATA_W | Read data, valid with mdio_done |
| reply_data | output | 8*REPLY_MAX | Reply bytes, byte n at bits 8n+7:8n |
| reply_len | output | $clog2(REPLY_MAX+1) | Reply byte count |
| reply_arm | output | 1 | One-cycle pulse: reply is ready |
| hs_ack | output | 1 | One-cycle handshake acknowledge pulse |

## Verification
Writes and reads are driven with several address and data patterns. Some use asymmetric byte values so that a swapped echo order or a swapped data byte order shows up. Others set high PHY and register bits and pass address bytes with non-zero upper bits, which exposes bad field masking or a header built with the wrong op code. Probe, unknown-code and non-vendor packets tell real decoding apart from matching on the code alone. A strobe sent mid-transaction, together with a delayed done, separates correct busy handling and request holding from a design that rearms early or lets a new packet overwrite the one in progress.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
  typedef enum logic [1:0] {
    K_NONE,
    K_PROBE,
    K_WRITE,
    K_READ
  } req_kind_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_XFER,
    S_PACK,
    S_ACK
  } seq_state_t;
endpackage

// File: rtl/vreq_decode.sv
module vreq_decode
  import vreq_pkg::*;
#(
  parameter logic [7:0] CODE_PROBE = 8'h20,
  parameter logic [7:0] CODE_WRITE = 8'h21,
  parameter logic [7:0] CODE_READ  = 8'h22
) (
  input  logic [1:0] req_type,
  input  logic [7:0] req_code,
  output req_kind_t  kind
);
  localparam logic [1:0] TYPE_VENDOR = 2'b10;

  always_comb begin
    kind = K_NONE;
    if (req_type == TYPE_VENDOR) begin
      unique case (req_code)
        CODE_PROBE: kind = K_PROBE;
        CODE_WRITE: kind = K_WRITE;
        CODE_READ:  kind = K_READ;
        default:    kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_hdr_gen.sv
module mdio_hdr_gen #(
  parameter int PHY_W = 5,
  parameter int REG_W = 5,
  localparam int HDR_W = 6 + PHY_W + REG_W
) (
  input  logic             is_write,
  input  logic [PHY_W-1:0] phy,
  input  logic [REG_W-1:0] regn,
  output logic [HDR_W-1:0] hdr
);
  localparam logic [1:0] START_BITS = 2'b01;
  localparam logic [1:0] OP_WR      = 2'b01;
  localparam logic [1:0] OP_RD      = 2'b10;
  localparam logic [1:0] TURN_BITS  = 2'b10;

  always_comb begin
    hdr = {START_BITS, (is_write ? OP_WR : OP_RD), phy, regn, TURN_BITS};
  end
endmodule

// File: rtl/vreq_reply_pack.sv
module vreq_reply_pack
  import vreq_pkg::*;
#(
  parameter int         REPLY_MAX  = 8,
  parameter int         DATA_W     = 16,
  parameter logic [7:0] PROBE_BYTE = 8'h15,
  localparam int        ECHO_N     = 6,
  localparam int        LEN_W      = $clog2(REPLY_MAX + 1)
) (
  input  req_kind_t               kind,
  input  logic [8*ECHO_N-1:0]     echo_bytes,
  input  logic [DATA_W-1:0]       rdata,
  input  logic [15:0]             hdr,
  output logic [8*REPLY_MAX-1:0]  bytes_out,
  output logic [LEN_W-1:0]        len_out
);
  localparam int FULL_LEN = ECHO_N + 2;

  logic xact;
  assign xact = (kind == K_WRITE) || (kind == K_READ);

  // echo section: reply byte i carries request parameter byte i
  for (genvar i = 0; i < ECHO_N; i++) begin : g_echo
    always_comb begin
      if (xact) bytes_out[8*i +: 8] = echo_bytes[8*i +: 8];
      else if (i == 0 && kind == K_PROBE) bytes_out[8*i +: 8] = PROBE_BYTE;
      else bytes_out[8*i +: 8] = 8'h00;
    end
  end

  // tail section: header low-first for writes, data high-first for reads
  always_comb begin
    unique case (kind)
      K_WRITE: bytes_out[8*ECHO_N +: 16] = {hdr[15:8], hdr[7:0]};
      K_READ:  bytes_out[8*ECHO_N +: 16] = {rdata[7:0], rdata[15:8]};
      default: bytes_out[8*ECHO_N +: 16] = 16'h0000;
    endcase
  end

  for (genvar j = FULL_LEN; j < REPLY_MAX; j++) begin : g_pad
    assign bytes_out[8*j +: 8] = 8'h00;
  end

  always_comb begin
    unique case (kind)
      K_PROBE: len_out = LEN_W'(1);
      K_WRITE, K_READ: len_out = LEN_W'(FULL_LEN);
      default: len_out = '0;
    endcase
  end
endmodule

// File: rtl/vreq_mdio_bridge.sv
module vreq_mdio_bridge
  import vreq_pkg::*;
#(
  parameter int         PHY_W      = 5,
  parameter int         REG_W      = 5,
  parameter int         DATA_W     = 16,
  parameter int         REPLY_MAX  = 8,
  parameter logic [7:0] CODE_PROBE = 8'h20,
  parameter logic [7:0] CODE_WRITE = 8'h21,
  parameter logic [7:0] CODE_READ  = 8'h22,
  parameter logic [7:0] PROBE_BYTE = 8'h15,
  localparam int        LEN_W      = $clog2(REPLY_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   setup_valid,
  input  logic [63:0]            setup_data,
  output logic                   mdio_req,
  output logic                   mdio_write,
  output logic [PHY_W-1:0]       mdio_phy,
  output logic [REG_W-1:0]       mdio_reg,
  output logic [DATA_W-1:0]      mdio_wdata,
  input  logic                   mdio_done,
  input  logic [DATA_W-1:0]      mdio_rdata,
  output logic [8*REPLY_MAX-1:0] reply_data,
  output logic [LEN_W-1:0]       reply_len,
  output logic                   reply_arm,
  output logic                   hs_ack
);
  localparam int ECHO_N = 6;

  seq_state_t             st;
  req_kind_t              kind_in, kind_q;
  logic [8*ECHO_N-1:0]    parm_q;
  logic [DATA_W-1:0]      rdata_q;
  logic [15:0]            hdr;
  logic [8*REPLY_MAX-1:0] pack_bytes;
  logic [LEN_W-1:0]       pack_len;

  vreq_decode #(
    .CODE_PROBE(CODE_PROBE),
    .CODE_WRITE(CODE_WRITE),
    .CODE_READ (CODE_READ)
  ) u_decode (
    .req_type(setup_data[6:5]),
    .req_code(setup_data[15:8]),
    .kind    (kind_in)
  );

  // parm_q byte k = setup byte k+2
  assign mdio_phy   = parm_q[PHY_W-1:0];
  assign mdio_reg   = parm_q[8 +: REG_W];
  assign mdio_wdata = {parm_q[24 +: 8], parm_q[16 +: 8]};
  assign mdio_write = (kind_q == K_WRITE);

  mdio_hdr_gen #(.PHY_W(PHY_W), .REG_W(REG_W)) u_hdr (
    .is_write(mdio_write),
    .phy     (mdio_phy),
    .regn    (mdio_reg),
    .hdr     (hdr)
  );

  vreq_reply_pack #(
    .REPLY_MAX (REPLY_MAX),
    .DATA_W    (DATA_W),
    .PROBE_BYTE(PROBE_BYTE)
  ) u_pack (
    .kind      (kind_q),
    .echo_bytes(parm_q),
    .rdata     (rdata_q),
    .hdr       (hdr),
    .bytes_out (pack_bytes),
    .len_out   (pack_len)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind_q     <= K_NONE;
      parm_q     <= '0;
      rdata_q    <= '0;
      mdio_req   <= 1'b0;
      reply_data <= '0;
      reply_len  <= '0;
      reply_arm  <= 1'b0;
      hs_ack     <= 1'b0;
    end else begin
      reply_arm <= 1'b0;
      hs_ack    <= 1'b0;
      unique case (st)
        S_IDLE: begin
          if (setup_valid && kind_in != K_NONE) begin
            kind_q <= kind_in;
            parm_q <= setup_data[63:16];
            if (kind_in == K_PROBE) begin
              st <= S_PACK;
            end else begin
              mdio_req <= 1'b1;
              st       <= S_XFER;
            end
          end
        end
        S_XFER: begin
          if (mdio_done) begin
            mdio_req <= 1'b0;
            rdata_q  <= mdio_rdata;
            st       <= S_PACK;
          end
        end
        S_PACK: begin
          reply_data <= pack_bytes;
          reply_len  <= pack_len;
          reply_arm  <= 1'b1;
          st         <= S_ACK;
        end
        S_ACK: begin
          hs_ack <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mdio_req && !mdio_done |=> mdio_req) else $error("request dropped early"); // R12
  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
    mdio_req && !mdio_done |=> $stable(mdio_phy) && $stable(mdio_reg) && $stable(mdio_wdata)
      && $stable(mdio_write)) else $error("fields moved"); // R12
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    mdio_req && mdio_done |=> !mdio_req) else $error("request not released"); // R8
  AST_ARM_PULSE: assert property (@(posedge clk) disable iff (rst)
    reply_arm |=> !reply_arm) else $error("arm not a pulse"); // R8
  AST_ARM_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    reply_arm |-> !mdio_req) else $error("armed during transaction"); // R8
  AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    reply_arm |=> hs_ack) else $error("no acknowledge after arm"); // R9
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
    hs_ack |=> !hs_ack) else $error("ack not a pulse"); // R9
  AST_PROBE_BYTE: assert property (@(posedge clk) disable iff (rst)
    reply_arm && reply_len == LEN_W'(1) |-> reply_data[7:0] == PROBE_BYTE)
    else $error("probe byte wrong"); // R2
endmodule

// File: tb/vreq_mdio_bridge_bench.sv
module vreq_mdio_bridge_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setup_valid = 1'b0;
  logic [63:0] setup_data = '0;
  logic        mdio_done = 1'b0;
  logic [15:0] mdio_rdata = '0;
  logic        mdio_req, mdio_write, reply_arm, hs_ack;
  logic [4:0]  mdio_phy, mdio_reg;
  logic [15:0] mdio_wdata;
  logic [63:0] reply_data;
  logic [3:0]  reply_len;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  vreq_mdio_bridge u_vreq_mdio_bridge (
    .clk(clk), .rst(rst), .setup_valid(setup_valid), .setup_data(setup_data),
    .mdio_req(mdio_req), .mdio_write(mdio_write), .mdio_phy(mdio_phy),
    .mdio_reg(mdio_reg), .mdio_wdata(mdio_wdata), .mdio_done(mdio_done),
    .mdio_rdata(mdio_rdata), .reply_data(reply_data), .reply_len(reply_len),
    .reply_arm(reply_arm), .hs_ack(hs_ack)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] ty, input logic [7:0] code,
      input logic [7:0] b2, b3, b4, b5, b6, b7);
    return {b7, b6, b5, b4, b3, b2, code, ty};
  endfunction

  function automatic logic [15:0] hdr_of(input logic w, input logic [4:0] p, input logic [4:0] r);
    return {2'b01, (w ? 2'b01 : 2'b10), p, r, 2'b10};
  endfunction

  task automatic send(input logic [63:0] s);
    @(negedge clk); setup_valid = 1'b1; setup_data = s;
    @(negedge clk); setup_valid = 1'b0;
  endtask

  // completes a pending transaction and checks the reply sequence
  task automatic finish(input string tag, input logic [15:0] rd, input logic [63:0] exp_reply);
    mdio_done = 1'b1; mdio_rdata = rd;
    @(negedge clk); mdio_done = 1'b0; mdio_rdata = 16'hxxxx;
    chk({tag, " R8 req released"}, {63'd0, mdio_req}, 64'd0);
    chk({tag, " R8 not armed yet"}, {63'd0, reply_arm}, 64'd0);
    @(negedge clk);
    chk({tag, " R8 arm"}, {63'd0, reply_arm}, 64'd1);
    chk({tag, " R5 len"}, {60'd0, reply_len}, 64'd8);
    chk({tag, " R5/R6/R7 reply"}, reply_data, exp_reply);
    @(negedge clk);
    chk({tag, " R9 ack"}, {62'd0, reply_arm, hs_ack}, 64'd1);
    @(negedge clk);
    chk({tag, " R9 ack pulse"}, {63'd0, hs_ack}, 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 req", {63'd0, mdio_req}, 64'd0);
    chk("R1 arm/ack", {62'd0, reply_arm, hs_ack}, 64'd0);
    chk("R1 len", {60'd0, reply_len}, 64'd0);
    chk("R1 data", reply_data, 64'd0);
  endtask

  task automatic t_probe;
    send(mk(8'hC0, 8'h20, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66));
    chk("R2 no mdio", {63'd0, mdio_req}, 64'd0);
    @(negedge clk);
    chk("R2 arm", {63'd0, reply_arm}, 64'd1);
    chk("R2 len", {60'd0, reply_len}, 64'd1);
    chk("R2 byte0", {56'd0, reply_data[7:0]}, 64'h15);
    @(negedge clk);
    chk("R9 probe ack", {62'd0, reply_arm, hs_ack}, 64'd1);
    @(negedge clk);
  endtask

  task automatic t_write(input logic [7:0] p, r, lo, hi, b6, b7, input int wait_n);
    logic [63:0] s;
    logic [15:0] h;
    s = mk(8'h40, 8'h21, p, r, lo, hi, b6, b7);
    h = hdr_of(1'b1, p[4:0], r[4:0]);
    send(s);
    chk("R3 req", {63'd0, mdio_req}, 64'd1);
    chk("R3 write", {63'd0, mdio_write}, 64'd1);
    chk("R3 phy/reg", {54'd0, mdio_phy, mdio_reg}, {54'd0, p[4:0], r[4:0]});
    chk("R3 wdata", {48'd0, mdio_wdata}, {48'd0, hi, lo});
    repeat (wait_n) @(negedge clk);
    chk("R12 req held", {63'd0, mdio_req}, 64'd1);
    chk("R8 no early arm", {63'd0, reply_arm}, 64'd0);
    finish("write", 16'hDEAD, {h[15:8], h[7:0], s[63:16]});
  endtask

  task automatic t_read(input logic [7:0] p, r, input logic [15:0] rd);
    logic [63:0] s;
    s = mk(8'hC0, 8'h22, p, r, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    send(s);
    chk("R4 req", {63'd0, mdio_req}, 64'd1);
    chk("R4 read", {63'd0, mdio_write}, 64'd0);
    chk("R4 phy/reg", {54'd0, mdio_phy, mdio_reg}, {54'd0, p[4:0], r[4:0]});
    @(negedge clk);
    finish("read", rd, {rd[7:0], rd[15:8], s[63:16]});
  endtask

  task automatic watch_idle(input string tag);
    for (int i = 0; i < 6; i++) begin
      if (mdio_req || reply_arm || hs_ack) begin
        chk({tag, " activity"}, {61'd0, mdio_req, reply_arm, hs_ack}, 64'd0);
        return;
      end
      @(negedge clk);
    end
    chk({tag, " quiet"}, {61'd0, mdio_req, reply_arm, hs_ack}, 64'd0);
  endtask

  task automatic t_unknown;
    send(mk(8'h40, 8'h23, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06));
    watch_idle("R10 code 0x23");
    send(mk(8'h40, 8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06));
    watch_idle("R10 code 0x00");
  endtask

  task automatic t_nonvendor;
    send(mk(8'h00, 8'h21, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06));
    watch_idle("R11 standard type");
    send(mk(8'h20, 8'h22, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06));
    watch_idle("R11 class type");
  endtask

  task automatic t_busy;
    logic [63:0] s;
    logic [15:0] h;
    s = mk(8'h40, 8'h21, 8'h07, 8'h09, 8'h5A, 8'hA5, 8'h3C, 8'hC3);
    h = hdr_of(1'b1, 5'd7, 5'd9);
    send(s);
    send(mk(8'h40, 8'h21, 8'h1F, 8'h1F, 8'hFF, 8'hFF, 8'hFF, 8'hFF));
    send(mk(8'h40, 8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00));
    chk("R12 fields kept", {38'd0, mdio_phy, mdio_reg, mdio_wdata},
        {38'd0, 5'd7, 5'd9, 16'hA55A});
    chk("R12 no arm while busy", {63'd0, reply_arm}, 64'd0);
    finish("busy", 16'h0000, {h[15:8], h[7:0], s[63:16]});
    watch_idle("R12 no late reply");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_probe();
    t_write(8'h03, 8'h11, 8'h34, 8'h12, 8'h77, 8'h88, 0);
    t_write(8'hFF, 8'hFE, 8'hCD, 8'hAB, 8'h00, 8'h01, 5);
    t_read(8'h15, 8'h0A, 16'hBEEF);
    t_read(8'hE0, 8'h1F, 16'h0102);
    t_unknown();
    t_nonvendor();
    t_busy();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule